// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block drives the opening phase of a raw NAND flash read on an 8-bit bus. The core raises `req_start` for one cycle, together with a block number, a page index inside that block, a column offset and an opcode byte. While the block is idle it accepts the request and raises `busy`. It then waits for the device to report ready and sends the opcode with the command latch high. Next it sends the column and row bytes with the address latch high. In large-page builds it also sends a read-confirm command. A final wait for ready follows, and then `busy` drops.

The device geometry is fixed at elaboration: page size, pages per block, small-page or large-page address format, and whether the extra row address byte is sent. The ready/busy line passes through a two-stage synchroniser. A build with no ready/busy line waits a fixed number of cycles instead. Data transfer after the address phase is left to other logic.

Top module: `nseq_cmd_seq`

## Requirements
- R1: The row address is `page + block * PAGES_PER_BLK`. Row bits [7:0] and [15:8] are sent as separate address bytes, low byte first.
- R2: Before the opcode byte, no write strobe falls until the ready input has been high (1 = ready) through the synchroniser. With `HAS_RB = 0`, the first strobe fall comes exactly `WAIT_CYC` cycles after `busy` rises.
- R3: The command latch and the address latch are never high together. The opcode byte and the confirm byte are sent with `nf_cle` = 1 and `nf_ale` = 0. Every address byte is sent with `nf_ale` = 1 and `nf_cle` = 0.
- R4: In large-page mode the byte order is as follows: opcode, column[7:0], column[15:8], row[7:0], row[15:8], the optional extra row byte, and then the confirm command 0x30.
- R5: In small-page mode the byte order is as follows: opcode, column[7:0], row[7:0], row[15:8], and the optional extra row byte. No confirm command is sent, and column bits above 7 are not sent.
- R6: In large-page mode, opcode 0x50 (spare-area read) is sent as opcode 0x00, and `PAGE_BYTES` is added to the column. In small-page mode, 0x50 is sent unchanged.
- R7: Each byte holds `nf_we_n` low for exactly `WE_LOW_CYC` cycles. `nf_dq` does not change on the cycle in which `nf_we_n` rises.
- R8: `busy` rises one cycle after an accepted `req_start`. While `busy` is high, `req_start` is ignored. While `busy` is low, the bus is quiet: `nf_we_n` = 1 and both latches are 0.
- R9: After the last byte there is a second wait for ready. With `HAS_RB = 1`, `busy` stays high while the ready input is low. With `HAS_RB = 0`, `busy` falls `WAIT_CYC + 1` cycles after the last rising edge of the strobe.
- R10: The extra row byte, when enabled by `EXTRA_ROW`, is `{4'h0, row[19:16]}`. Row bits 20 and above are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_start | input | 1 | One-cycle request pulse, taken only while idle |
| req_block | input | BLK_W | Block number |
| req_page | input | PG_W | Page index inside the block |
| req_col | input | COL_W | Column offset inside the page |
| req_op | input | 8 | Opcode byte (0x50 is a spare-area read) |
| rb_i | input | 1 | Device ready/busy line, 1 = ready, asynchronous |
| busy | output | 1 | High from acceptance until the final wait ends |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_dq | output | 8 | Bus byte being written |

## Verification
`busy` is due one cycle after the accepting edge. With no ready line, the first strobe fall is due `WAIT_CYC` cycles after that. Each byte then takes `WE_LOW_CYC + 1` cycles, and `busy` falls `WAIT_CYC + 1` cycles after the last rising strobe. The bench samples on falling clock edges and counts those samples between the rise of `busy`, the first strobe fall, the last strobe rise and the fall of `busy`. It compares the counts with these figures. Byte content and latch state are captured at each rising strobe, so the order checks do not depend on timing. The ready-gated build is checked by holding the ready input low for longer than any valid delay and confirming that no byte and no drop of `busy` appears in that time.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_SEND,
    ST_POST
  } seq_st_e;

  typedef enum logic {
    BK_CMD,
    BK_ADDR
  } byte_kind_e;

  typedef struct packed {
    byte_kind_e kind;
    logic [7:0] data;
  } bus_byte_t;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_SPARE   = 8'h50;
  localparam logic [7:0] OP_CONFIRM = 8'h30;
  localparam int         MAX_BYTES  = 7;
  localparam int         IDX_W      = 3;

endpackage

// File: rtl/nseq_ready_wait.sv
module nseq_ready_wait
  import nseq_pkg::*;
#(
  parameter int HAS_RB   = 1,
  parameter int WAIT_CYC = 12,
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_i,
  input  logic go_i,
  output logic done_o
);

  localparam int LIMIT = (HAS_RB != 0) ? SYNC_STG : WAIT_CYC - 1;
  localparam int CW    = $clog2(LIMIT + 2) + 1;

  logic [SYNC_STG-1:0] sync_q;
  logic                rb_s;
  logic                act_q, act_nx;
  logic [CW-1:0]       cnt_q, cnt_nx;
  logic                limit_hit;

  // two-stage synchroniser on the ready line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STG-2:0], rb_i};
  end
  assign rb_s = sync_q[SYNC_STG-1];

  assign limit_hit = (cnt_q == CW'(LIMIT));
  assign done_o    = act_q && limit_hit && ((HAS_RB == 0) || rb_s);

  always_comb begin
    act_nx = act_q;
    cnt_nx = cnt_q;
    if (go_i) begin
      act_nx = 1'b1;
      cnt_nx = '0;
    end else if (act_q) begin
      if (done_o)          act_nx = 1'b0;
      else if (!limit_hit) cnt_nx = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_nx;
      cnt_q <= cnt_nx;
    end
  end

  // R2 / R9: with a ready line, a wait only ends on a ready level seen through the synchroniser
  a_r2_ready_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_RB != 0 && done_o) |-> $past(rb_i, SYNC_STG));

  // a new wait is never started while one is running
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !act_q);

endmodule

// File: rtl/nseq_strobe.sv
module nseq_strobe
  import nseq_pkg::*;
#(
  parameter int LOW_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      launch_i,
  input  bus_byte_t byte_i,
  output logic      fin_o,
  output logic      we_n_o,
  output logic      cle_o,
  output logic      ale_o,
  output logic [7:0] dq_o
);

  localparam int CW = $clog2(LOW_CYC + 1) + 1;

  logic          low_q, low_nx;
  logic          hi_q, hi_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          we_q, we_nx;
  logic          cle_q, cle_nx;
  logic          ale_q, ale_nx;
  logic [7:0]    dq_q, dq_nx;

  always_comb begin
    low_nx = low_q;
    hi_nx  = hi_q;
    cnt_nx = cnt_q;
    we_nx  = we_q;
    cle_nx = cle_q;
    ale_nx = ale_q;
    dq_nx  = dq_q;
    if (launch_i) begin
      low_nx = 1'b1;
      hi_nx  = 1'b0;
      cnt_nx = '0;
      we_nx  = 1'b0;
      dq_nx  = byte_i.data;
      cle_nx = (byte_i.kind == BK_CMD);
      ale_nx = (byte_i.kind == BK_ADDR);
    end else if (low_q) begin
      if (cnt_q == CW'(LOW_CYC - 1)) begin
        low_nx = 1'b0;
        hi_nx  = 1'b1;
        we_nx  = 1'b1;
      end else begin
        cnt_nx = cnt_q + CW'(1);
      end
    end else if (hi_q) begin
      hi_nx  = 1'b0;
      cle_nx = 1'b0;
      ale_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      hi_q  <= 1'b0;
      cnt_q <= '0;
      we_q  <= 1'b1;
      cle_q <= 1'b0;
      ale_q <= 1'b0;
      dq_q  <= '0;
    end else begin
      low_q <= low_nx;
      hi_q  <= hi_nx;
      cnt_q <= cnt_nx;
      we_q  <= we_nx;
      cle_q <= cle_nx;
      ale_q <= ale_nx;
      dq_q  <= dq_nx;
    end
  end

  assign fin_o  = hi_q;
  assign we_n_o = we_q;
  assign cle_o  = cle_q;
  assign ale_o  = ale_q;
  assign dq_o   = dq_q;

  // R7: data and latch levels hold across the rising strobe
  a_r7_dq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> ($stable(dq_o) && $stable(cle_o) && $stable(ale_o)));

  // R7: a new byte is never launched while the strobe is still low
  a_r7_launch_legal: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> we_n_o);

  generate
    if (LOW_CYC >= 2) begin : g_wide
      // R7: the low phase lasts more than one cycle
      a_r7_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n_o) |=> !we_n_o);
    end
  endgenerate

endmodule

// File: rtl/nseq_addr_form.sv
module nseq_addr_form
  import nseq_pkg::*;
#(
  parameter int LARGE_PAGE    = 1,
  parameter int EXTRA_ROW     = 0,
  parameter int PAGE_BYTES    = 2048,
  parameter int PAGES_PER_BLK = 64,
  parameter int BLK_W         = 16,
  parameter int PG_W          = 6,
  parameter int COL_W         = 16
) (
  input  logic [BLK_W-1:0]               blk_i,
  input  logic [PG_W-1:0]                pg_i,
  input  logic [COL_W-1:0]               col_i,
  input  logic [7:0]                     op_i,
  output bus_byte_t [MAX_BYTES-1:0]      seq_o,
  output logic [IDX_W-1:0]               n_bytes_o
);

  localparam int RFULL = BLK_W + PG_W;
  localparam int RW    = (RFULL > 24) ? RFULL : 24;
  localparam int CW2   = (COL_W > 16) ? COL_W : 16;

  logic [RW-1:0]  row;
  logic [7:0]     row_xtra;
  logic [CW2-1:0] col_w;

  // R1: linear row number
  assign row      = RW'(pg_i) + RW'(blk_i) * RW'(PAGES_PER_BLK);
  // R10: extra row byte carries only four bits
  assign row_xtra = {4'h0, row[19:16]};
  assign col_w    = CW2'(col_i);

  generate
    if (LARGE_PAGE != 0) begin : g_large
      logic           spare;
      logic [7:0]     op_eff;
      logic [CW2-1:0] col_eff;
      logic           unused_large;

      // R6: spare-area read becomes a plain read past the page end
      assign spare   = (op_i == OP_SPARE);
      assign op_eff  = spare ? OP_READ : op_i;
      assign col_eff = spare ? col_w + CW2'(PAGE_BYTES) : col_w;

      always_comb begin
        seq_o    = '0;
        seq_o[0] = '{kind: BK_CMD,  data: op_eff};
        seq_o[1] = '{kind: BK_ADDR, data: col_eff[7:0]};
        seq_o[2] = '{kind: BK_ADDR, data: col_eff[15:8]};
        seq_o[3] = '{kind: BK_ADDR, data: row[7:0]};
        seq_o[4] = '{kind: BK_ADDR, data: row[15:8]};
        if (EXTRA_ROW != 0) begin
          seq_o[5]  = '{kind: BK_ADDR, data: row_xtra};
          seq_o[6]  = '{kind: BK_CMD,  data: OP_CONFIRM};
          n_bytes_o = IDX_W'(7);
        end else begin
          seq_o[5]  = '{kind: BK_CMD,  data: OP_CONFIRM};
          n_bytes_o = IDX_W'(6);
        end
      end

      assign unused_large = ^{row[RW-1:20], col_eff[CW2-1:16]};
    end else begin : g_small
      logic unused_small;

      always_comb begin
        seq_o    = '0;
        seq_o[0] = '{kind: BK_CMD,  data: op_i};
        seq_o[1] = '{kind: BK_ADDR, data: col_w[7:0]};
        seq_o[2] = '{kind: BK_ADDR, data: row[7:0]};
        seq_o[3] = '{kind: BK_ADDR, data: row[15:8]};
        if (EXTRA_ROW != 0) begin
          seq_o[4]  = '{kind: BK_ADDR, data: row_xtra};
          n_bytes_o = IDX_W'(5);
        end else begin
          n_bytes_o = IDX_W'(4);
        end
      end

      assign unused_small = ^{row[RW-1:20], col_w[CW2-1:8]};
    end
  endgenerate

endmodule

// File: rtl/nseq_cmd_seq.sv
module nseq_cmd_seq
  import nseq_pkg::*;
#(
  parameter int LARGE_PAGE    = 1,
  parameter int EXTRA_ROW     = 0,
  parameter int PAGE_BYTES    = 2048,
  parameter int PAGES_PER_BLK = 64,
  parameter int BLK_W         = 16,
  parameter int COL_W         = 16,
  parameter int HAS_RB        = 1,
  parameter int WAIT_CYC      = 12,
  parameter int WE_LOW_CYC    = 2,
  localparam int PG_W         = $clog2(PAGES_PER_BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic [BLK_W-1:0] req_block,
  input  logic [PG_W-1:0]  req_page,
  input  logic [COL_W-1:0] req_col,
  input  logic [7:0]       req_op,
  input  logic             rb_i,
  output logic             busy,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic [7:0]       nf_dq
);

  seq_st_e                 st_q, st_nx;
  logic [IDX_W-1:0]        idx_q, idx_nx;
  logic [BLK_W-1:0]        blk_q;
  logic [PG_W-1:0]         pg_q;
  logic [COL_W-1:0]        col_q;
  logic [7:0]              op_q;
  bus_byte_t [MAX_BYTES-1:0] seq;
  logic [IDX_W-1:0]        n_bytes;
  logic [IDX_W-1:0]        launch_idx;
  logic                    accept, last, fin, done, go, launch;

  // request capture, enabled only on acceptance
  assign accept = (st_q == ST_IDLE) && req_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      pg_q  <= '0;
      col_q <= '0;
      op_q  <= '0;
    end else if (accept) begin
      blk_q <= req_block;
      pg_q  <= req_page;
      col_q <= req_col;
      op_q  <= req_op;
    end
  end

  nseq_addr_form #(
    .LARGE_PAGE   (LARGE_PAGE),
    .EXTRA_ROW    (EXTRA_ROW),
    .PAGE_BYTES   (PAGE_BYTES),
    .PAGES_PER_BLK(PAGES_PER_BLK),
    .BLK_W        (BLK_W),
    .PG_W         (PG_W),
    .COL_W        (COL_W)
  ) u_form (
    .blk_i    (blk_q),
    .pg_i     (pg_q),
    .col_i    (col_q),
    .op_i     (op_q),
    .seq_o    (seq),
    .n_bytes_o(n_bytes)
  );

  nseq_ready_wait #(
    .HAS_RB  (HAS_RB),
    .WAIT_CYC(WAIT_CYC),
    .SYNC_STG(2)
  ) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .rb_i  (rb_i),
    .go_i  (go),
    .done_o(done)
  );

  nseq_strobe #(
    .LOW_CYC(WE_LOW_CYC)
  ) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch_i(launch),
    .byte_i  (seq[launch_idx]),
    .fin_o   (fin),
    .we_n_o  (nf_we_n),
    .cle_o   (nf_cle),
    .ale_o   (nf_ale),
    .dq_o    (nf_dq)
  );

  assign last       = (idx_q == n_bytes - IDX_W'(1));
  assign launch_idx = (st_q == ST_PRE) ? '0 : idx_q + IDX_W'(1);
  assign go         = accept || ((st_q == ST_SEND) && fin && last);
  assign launch     = ((st_q == ST_PRE) && done) || ((st_q == ST_SEND) && fin && !last);

  always_comb begin
    st_nx  = st_q;
    idx_nx = idx_q;
    if (launch) idx_nx = launch_idx;
    unique case (st_q)
      ST_IDLE: if (accept)      st_nx = ST_PRE;
      ST_PRE:  if (done)        st_nx = ST_SEND;
      ST_SEND: if (fin && last) st_nx = ST_POST;
      ST_POST: if (done)        st_nx = ST_IDLE;
      default:                  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_nx;
      idx_q <= idx_nx;
    end
  end

  assign busy = (st_q != ST_IDLE);

  // R3: latches are mutually exclusive
  a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  // R8: idle bus is quiet
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nf_we_n && !nf_cle && !nf_ale));

  // R8: busy only rises after a start request
  a_r8_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_start));

  // R4 / R5: the address phase directly follows the opcode byte
  a_r4_ale_after_cle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_ale) |-> $past(nf_cle));

endmodule

// File: tb/sim_nseq_cmd_seq.sv
`timescale 1ns/1ps
module sim_nseq_cmd_seq;

  localparam int W0 = 12, L0 = 2, PPB0 = 64;
  localparam int W1 = 9,  L1 = 3, PPB1 = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        st0 = 1'b0, st1 = 1'b0;
  logic [15:0] blk = '0;
  logic [5:0]  pg0 = '0;
  logic [4:0]  pg1 = '0;
  logic [15:0] col = '0;
  logic [7:0]  op  = '0;
  logic        rb0 = 1'b1;

  logic       b0, cl0, al0, w0, b1, cl1, al1, w1;
  logic [7:0] d0, d1;

  int checks = 0, errors = 0;

  nseq_cmd_seq #(.LARGE_PAGE(1), .EXTRA_ROW(0), .PAGE_BYTES(2048), .PAGES_PER_BLK(PPB0),
                 .BLK_W(16), .COL_W(16), .HAS_RB(1), .WAIT_CYC(W0), .WE_LOW_CYC(L0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_start(st0), .req_block(blk), .req_page(pg0),
    .req_col(col), .req_op(op), .rb_i(rb0), .busy(b0), .nf_cle(cl0), .nf_ale(al0),
    .nf_we_n(w0), .nf_dq(d0));

  nseq_cmd_seq #(.LARGE_PAGE(0), .EXTRA_ROW(1), .PAGE_BYTES(512), .PAGES_PER_BLK(PPB1),
                 .BLK_W(16), .COL_W(16), .HAS_RB(0), .WAIT_CYC(W1), .WE_LOW_CYC(L1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_start(st1), .req_block(blk), .req_page(pg1),
    .req_col(col), .req_op(op), .rb_i(1'b0), .busy(b1), .nf_cle(cl1), .nf_ale(al1),
    .nf_we_n(w1), .nf_dq(d1));

  // byte capture at each rising strobe
  logic [7:0] c0_dq [16];
  logic       c0_cl [16], c0_al [16];
  int         n0 = 0;
  logic [7:0] c1_dq [16];
  logic       c1_cl [16], c1_al [16];
  int         n1 = 0;

  always @(posedge w0) if (rst_n && n0 < 16) begin
    c0_dq[n0] = d0; c0_cl[n0] = cl0; c0_al[n0] = al0; n0++;
  end
  always @(posedge w1) if (rst_n && n1 < 16) begin
    c1_dq[n1] = d1; c1_cl[n1] = cl1; c1_al[n1] = al1; n1++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // exp packs byte i at [8*i +: 8]; cmask bit i = 1 means command byte
  task automatic cmp0(input string req, input int n, input logic [63:0] exp, input logic [7:0] cmask);
    chk(n0 == n, {req, " byte count"}, n0, n);
    for (int i = 0; i < n && i < n0; i++) begin
      chk(c0_dq[i] == exp[8*i +: 8], req, c0_dq[i], exp[8*i +: 8]);
      chk(c0_cl[i] == cmask[i] && c0_al[i] == !cmask[i], {req, " R3 latch"},
          {c0_cl[i], c0_al[i]}, {cmask[i], !cmask[i]});
    end
  endtask

  task automatic cmp1(input string req, input int n, input logic [63:0] exp, input logic [7:0] cmask);
    chk(n1 == n, {req, " byte count"}, n1, n);
    for (int i = 0; i < n && i < n1; i++) begin
      chk(c1_dq[i] == exp[8*i +: 8], req, c1_dq[i], exp[8*i +: 8]);
      chk(c1_cl[i] == cmask[i] && c1_al[i] == !cmask[i], {req, " R3 latch"},
          {c1_cl[i], c1_al[i]}, {cmask[i], !cmask[i]});
    end
  endtask

  task automatic start0(input logic [7:0] o, input logic [15:0] b, input logic [5:0] p, input logic [15:0] c);
    @(negedge clk);
    op = o; blk = b; pg0 = p; col = c; n0 = 0; st0 = 1'b1;
    @(negedge clk);
    st0 = 1'b0;
  endtask

  task automatic wait_idle0();
    for (int k = 0; k < 2000 && b0; k++) @(negedge clk);
    chk(!b0, "R8 busy clears", b0, 0);
  endtask

  task automatic t_reset();
    chk(!b0 && w0 && !cl0 && !al0, "R8 reset u0", {b0, w0, cl0, al0}, 4'b0100);
    chk(!b1 && w1 && !cl1 && !al1, "R8 reset u1", {b1, w1, cl1, al1}, 4'b0100);
  endtask

  // R1 R4: row 0x123*64+7 = 0x48C7
  task automatic t_large_read();
    start0(8'h00, 16'h0123, 6'd7, 16'h01A4);
    wait_idle0();
    cmp0("R4 R1 large read", 6, 64'h0000_3048_C701_A400, 8'b10_0001);
  endtask

  // R6: 0x50 becomes 0x00, column 0x0005 + 2048 = 0x0805, row 2*64 = 0x80
  task automatic t_large_spare();
    start0(8'h50, 16'h0002, 6'd0, 16'h0005);
    wait_idle0();
    cmp0("R6 large spare", 6, 64'h0000_3000_8008_0500, 8'b10_0001);
  endtask

  // R2 R9: ready gating before and after the bytes
  task automatic t_ready_gate();
    rb0 = 1'b0;
    repeat (4) @(negedge clk);
    start0(8'h00, 16'h0001, 6'd1, 16'h0000);
    repeat (30) @(negedge clk);
    chk(n0 == 0 && w0 && b0, "R2 held while not ready", n0, 0);
    rb0 = 1'b1;
    for (int k = 0; k < 200 && n0 < 6; k++) @(negedge clk);
    rb0 = 1'b0;
    cmp0("R2 bytes after ready", 6, 64'h0000_3000_4100_0000, 8'b10_0001);
    repeat (20) @(negedge clk);
    chk(b0, "R9 busy held while not ready", b0, 1);
    rb0 = 1'b1;
    repeat (6) @(negedge clk);
    chk(!b0, "R9 busy drops after ready", b0, 0);
  endtask

  // R8: a second start while busy is ignored
  task automatic t_ignore_start();
    start0(8'h00, 16'h0003, 6'd2, 16'h0010);
    repeat (5) @(negedge clk);
    op = 8'h90; blk = 16'hFFFF; col = 16'hFFFF; st0 = 1'b1;
    @(negedge clk);
    st0 = 1'b0;
    wait_idle0();
    // row 3*64+2 = 0xC2
    cmp0("R8 start ignored", 6, 64'h0000_3000_C200_1000, 8'b10_0001);
    repeat (3) @(negedge clk);
    chk(!b0 && n0 == 6, "R8 no second run", n0, 6);
  endtask

  // R5 R10 R2 R7 R9: small page, fixed delay; row 0xABCD*32+5 = 0x1579A5
  task automatic t_small(input logic [7:0] o, input logic [63:0] exp, input string req, input bit timing);
    int k, kb, kw, kr, kf, lowrun, firstlow;
    logic pw;
    @(negedge clk);
    op = o; blk = 16'hABCD; pg1 = 5'd5; col = 16'h12F0; n1 = 0; st1 = 1'b1;
    @(negedge clk);
    st1 = 1'b0;
    k = 1; kb = -1; kw = -1; kr = -1; kf = -1; lowrun = 0; firstlow = -1; pw = 1'b1;
    while (k < 2000 && kf < 0) begin
      if (b1 && kb < 0) kb = k;
      if (!w1 && kw < 0) kw = k;
      if (!w1) lowrun++;
      if (w1 && !pw) begin
        kr = k;
        if (firstlow < 0) firstlow = lowrun;
        lowrun = 0;
      end
      if (!b1 && kb >= 0) kf = k;
      pw = w1;
      @(negedge clk);
      k++;
    end
    cmp1(req, 5, exp, 8'b0_0001);
    if (timing) begin
      chk(kw - kb == W1, "R2 fixed delay before first strobe", kw - kb, W1);
      chk(firstlow == L1, "R7 strobe low width", firstlow, L1);
      chk(kf - kr == W1 + 1, "R9 fixed delay after last strobe", kf - kr, W1 + 1);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_large_read();
    t_large_spare();
    t_ready_gate();
    t_ignore_start();
    t_small(8'h00, 64'h05_79A5_F000, "R5 R10 small read", 1'b1);
    t_small(8'h50, 64'h05_79A5_F050, "R6 small spare unchanged", 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule